// File: doc/BRIEF.md
# Multi-Level Test Symbol Receiver with Signature Retry

This block sits on the device side of a reduced-pin test link. Each test clock, it may receive one decoded 32-level symbol, given as five bits. It spreads those bits onto five parallel test signals in the same cycle: three general test inputs, one scan-in and one scan-enable. Clock and reset stay ordinary binary pins and are never carried in a symbol.

Every accepted symbol is also folded into a 16-bit multiple-input signature register. A single-cycle end-of-test strobe compares the folded signature with an expected value supplied by the tester.

- A match declares the device passing.
- A mismatch asks the tester to apply the whole pass again.
- The fourth failing compare declares the device failing.

Between passes the signature reloads to its seed, so every application of the test is judged on its own symbols only.

Top module: `mvl_test_rx`

## Requirements
- R1: While reset is high, and on the first clock after it, all five test outputs and pass, fail and retest_req are low.
- R2: A symbol accepted with sym_valid drives the outputs one clock later: bit0 to tst_g0, bit1 to tst_g1, bit2 to tst_g2, bit3 to tst_scan_in, bit4 to tst_scan_en.
- R3: While sym_valid is low the five test outputs keep their last values.
- R4: The signature starts each pass at 16'hFFFF. On each accepted symbol it advances one step:
  - shift left by one;
  - XOR with 16'h1021 when the old bit 15 was set;
  - XOR the symbol into bits 4:0.
  
  Cycles without sym_valid leave it unchanged.
- R5: A symbol accepted in the same cycle as end_of_test is part of the signature that is compared.
- R6: A compare that matches exp_sig raises pass on the next clock. Pass then stays high until reset.
- R7: A failing compare raises retest_req for exactly one clock on the next clock, provided fewer than four compares have failed. The signature reloads to 16'hFFFF after every compare.
- R8: The fourth failing compare raises fail on the next clock, with no retest_req. Fail then stays high until reset.
- R9: Once pass or fail is high, later end_of_test strobes change none of pass, fail or retest_req.
- R10: Pass and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_data | input | 5 | Decoded symbol bits |
| end_of_test | input | 1 | One-cycle strobe closing a test pass |
| exp_sig | input | 16 | Expected signature for the compare |
| tst_g0 | output | 1 | Test input lane 0 (symbol bit 0) |
| tst_g1 | output | 1 | Test input lane 1 (symbol bit 1) |
| tst_g2 | output | 1 | Test input lane 2 (symbol bit 2) |
| tst_scan_in | output | 1 | Scan data lane (symbol bit 3) |
| tst_scan_en | output | 1 | Scan enable lane (symbol bit 4) |
| pass | output | 1 | Device passed; held until reset |
| fail | output | 1 | Retry limit used up; held until reset |
| retest_req | output | 1 | One-clock request to reapply the pass |

## Verification
Every result of this block is registered and due exactly one rising edge after the stimulus that causes it:
- the five lanes follow the rising edge at which sym_valid was sampled;
- pass, fail and retest_req follow the edge at which end_of_test was sampled.

The bench drives each stimulus just after a falling edge. It then waits for the next falling edge and compares all eight outputs against its model at that point, so every check lands half a period after the single edge that should have produced the result. The model advances the signature, retry count and lane values in the same step, so no output is judged a cycle early or late.

// File: rtl/mvl_rx_pkg.sv
package mvl_rx_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PASS = 2'd1,
    ST_FAIL = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic scan_en;
    logic scan_in;
    logic g2;
    logic g1;
    logic g0;
  } test_lanes_t;

endpackage

// File: rtl/mvl_lane_split.sv
module mvl_lane_split #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  output logic [SYM_W-1:0] lanes
);

  // One register per lane, each loaded only when a symbol is accepted.
  for (genvar i = 0; i < SYM_W; i++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= 1'b0;
      end else if (sym_valid) begin
        lane_q <= sym_data[i];
      end
    end
    assign lanes[i] = lane_q;
  end

  // R3: with no valid symbol the lanes hold.
  p_lanes_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> $stable(lanes));

endmodule

// File: rtl/mvl_misr.sv
module mvl_misr #(
  parameter int              SIG_W = 16,
  parameter int              SYM_W = 5,
  parameter logic [SIG_W-1:0] POLY = 16'h1021,
  parameter logic [SIG_W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fold_en,
  input  logic [SYM_W-1:0] sym,
  input  logic             reseed,
  output logic [SIG_W-1:0] sig_q,
  output logic [SIG_W-1:0] sig_fold
);

  logic [SIG_W-1:0] shifted;
  logic [SIG_W-1:0] stepped;

  always_comb begin
    shifted = {sig_q[SIG_W-2:0], 1'b0} ^ (sig_q[SIG_W-1] ? POLY : '0);
    stepped = shifted;
    stepped[SYM_W-1:0] = shifted[SYM_W-1:0] ^ sym;
    sig_fold = fold_en ? stepped : sig_q;
  end

  always_ff @(posedge clk) begin
    if (rst || reseed) begin
      sig_q <= SEED;
    end else begin
      sig_q <= sig_fold;
    end
  end

  // R7: every compare is followed by a fresh seed.
  p_reseed_r7: assert property (@(posedge clk) disable iff (rst)
    reseed |=> (sig_q == SEED));

  // R4: idle cycles leave the signature alone.
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!fold_en && !reseed) |=> $stable(sig_q));

endmodule

// File: rtl/mvl_retry_ctrl.sv
module mvl_retry_ctrl
  import mvl_rx_pkg::*;
#(
  parameter int SIG_W     = 16,
  parameter int MAX_TRIES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_of_test,
  input  logic [SIG_W-1:0] sig_fold,
  input  logic [SIG_W-1:0] exp_sig,
  output logic             pass,
  output logic             fail,
  output logic             retest_req
);

  localparam int            TW     = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] LAST   = TW'(MAX_TRIES);
  localparam logic [TW-1:0] PENULT = TW'(MAX_TRIES - 1);

  rx_state_e     st_q;
  logic [TW-1:0] tries_q;
  logic          match;

  assign match = (sig_fold == exp_sig);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RUN;
      tries_q    <= '0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      retest_req <= 1'b0;
    end else begin
      retest_req <= 1'b0;
      if (end_of_test && st_q == ST_RUN) begin
        if (match) begin
          st_q <= ST_PASS;
          pass <= 1'b1;
        end else if (tries_q == PENULT) begin
          tries_q <= LAST;
          st_q    <= ST_FAIL;
          fail    <= 1'b1;
        end else begin
          tries_q    <= tries_q + 1'b1;
          retest_req <= 1'b1;
        end
      end
    end
  end

  p_pass_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    pass |=> pass);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    fail |=> fail);

  p_fail_at_limit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (tries_q == LAST));

  p_tries_bound_r8: assert property (@(posedge clk) disable iff (rst)
    tries_q <= LAST);

  p_retest_clean_r7: assert property (@(posedge clk) disable iff (rst)
    retest_req |-> (!pass && !fail));

  p_done_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |=> ($stable(tries_q) && !retest_req));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

endmodule

// File: rtl/mvl_test_rx.sv
module mvl_test_rx
  import mvl_rx_pkg::*;
#(
  parameter int               SYM_W     = 5,
  parameter int               SIG_W     = 16,
  parameter logic [SIG_W-1:0] POLY      = 16'h1021,
  parameter logic [SIG_W-1:0] SEED      = 16'hFFFF,
  parameter int               MAX_TRIES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             end_of_test,
  input  logic [SIG_W-1:0] exp_sig,
  output logic             tst_g0,
  output logic             tst_g1,
  output logic             tst_g2,
  output logic             tst_scan_in,
  output logic             tst_scan_en,
  output logic             pass,
  output logic             fail,
  output logic             retest_req
);

  logic [SYM_W-1:0] lanes;
  test_lanes_t      lane_s;
  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] sig_fold;

  mvl_lane_split #(.SYM_W(SYM_W)) u_split (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .lanes     (lanes)
  );

  mvl_misr #(
    .SIG_W (SIG_W),
    .SYM_W (SYM_W),
    .POLY  (POLY),
    .SEED  (SEED)
  ) u_misr (
    .clk      (clk),
    .rst      (rst),
    .fold_en  (sym_valid),
    .sym      (sym_data),
    .reseed   (end_of_test),
    .sig_q    (sig_q),
    .sig_fold (sig_fold)
  );

  mvl_retry_ctrl #(
    .SIG_W     (SIG_W),
    .MAX_TRIES (MAX_TRIES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .end_of_test (end_of_test),
    .sig_fold    (sig_fold),
    .exp_sig     (exp_sig),
    .pass        (pass),
    .fail        (fail),
    .retest_req  (retest_req)
  );

  assign lane_s      = test_lanes_t'(lanes[4:0]);
  assign tst_g0      = lane_s.g0;
  assign tst_g1      = lane_s.g1;
  assign tst_g2      = lane_s.g2;
  assign tst_scan_in = lane_s.scan_in;
  assign tst_scan_en = lane_s.scan_en;

  // R2: an accepted symbol appears on the lanes one clock later.
  p_lane_map_r2: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> ({tst_scan_en, tst_scan_in, tst_g2, tst_g1, tst_g0} == $past(sym_data[4:0])));

  // R4: at the very start of a pass the signature is the seed.
  p_seed_after_reset_r4: assert property (@(posedge clk)
    $fell(rst) |-> (sig_q == SEED));

endmodule

// File: tb/mvl_test_rx_bench.sv
module mvl_test_rx_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        sym_valid;
  logic [4:0]  sym_data;
  logic        end_of_test;
  logic [15:0] exp_sig;
  logic        tst_g0, tst_g1, tst_g2, tst_scan_in, tst_scan_en;
  logic        pass, fail, retest_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bench model of the expected behaviour.
  logic [15:0] m_sig;
  logic [4:0]  m_lanes;
  logic        m_pass, m_fail, m_retest;
  int          m_tries;

  always #10 clk = ~clk;

  mvl_test_rx u_mvl_test_rx (
    .clk         (clk),
    .rst         (rst),
    .sym_valid   (sym_valid),
    .sym_data    (sym_data),
    .end_of_test (end_of_test),
    .exp_sig     (exp_sig),
    .tst_g0      (tst_g0),
    .tst_g1      (tst_g1),
    .tst_g2      (tst_g2),
    .tst_scan_in (tst_scan_in),
    .tst_scan_en (tst_scan_en),
    .pass        (pass),
    .fail        (fail),
    .retest_req  (retest_req)
  );

  function automatic logic [15:0] misr_step(input logic [15:0] s, input logic [4:0] d);
    logic [15:0] n;
    n = {s[14:0], 1'b0};
    if (s[15]) n = n ^ 16'h1021;
    n[4:0] = n[4:0] ^ d;
    return n;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (retest,fail,pass,en,si,g2,g1,g0)", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {retest_req, fail, pass, tst_scan_en, tst_scan_in, tst_g2, tst_g1, tst_g0};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sym_valid = 1'b0; sym_data = '0; end_of_test = 1'b0; exp_sig = '0;
    @(negedge clk);
    check("R1", outs(), 8'h00);
    @(negedge clk);
    rst = 1'b0;
    m_sig = 16'hFFFF; m_lanes = '0; m_pass = 0; m_fail = 0; m_retest = 0; m_tries = 0;
    @(negedge clk);
    check("R1", outs(), 8'h00);
  endtask

  // One clock: drive after a falling edge, check at the next falling edge.
  task automatic cyc(input logic v, input logic [4:0] d, input logic e, input logic m,
                     input string tag);
    logic [15:0] fold;
    string       t;
    t = tag;
    fold = v ? misr_step(m_sig, d) : m_sig;
    sym_valid = v; sym_data = d; end_of_test = e;
    exp_sig = m ? fold : (fold ^ 16'h0100);
    if (v) m_lanes = d;
    m_retest = 1'b0;
    if (e) begin
      if (m_pass || m_fail) begin
        t = "R9";
      end else if (m) begin
        m_pass = 1'b1; t = "R6";
      end else begin
        m_tries++;
        if (m_tries == 4) begin m_fail = 1'b1; t = "R8"; end
        else begin m_retest = 1'b1; t = "R7"; end
      end
      m_sig = 16'hFFFF;
    end else begin
      m_sig = fold;
    end
    @(negedge clk);
    check(t, outs(), {m_retest, m_fail, m_pass, m_lanes});
    if (pass && fail) begin
      checks++; errors++;
      $display("FAIL R10 actual=pass&fail expected=exclusive");
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst = 1'b1; sym_valid = 1'b0; sym_data = '0; end_of_test = 1'b0; exp_sig = '0;
    do_reset();

    // R2: walk each bit to its lane, then R3 hold with garbage data.
    for (int i = 0; i < 5; i++) cyc(1'b1, 5'(1 << i), 1'b0, 1'b0, "R2");
    cyc(1'b1, 5'h15, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b0, 5'h0A, 1'b0, 1'b0, "R3");

    // R4: directed single zero symbol from seed -> 16'hEFDF, matched.
    do_reset();
    if (misr_step(16'hFFFF, 5'h00) !== 16'hEFDF) begin
      checks++; errors++;
      $display("FAIL R4 actual=%h expected=efdf", misr_step(16'hFFFF, 5'h00));
    end
    cyc(1'b1, 5'h00, 1'b0, 1'b0, "R4");
    cyc(1'b0, 5'h00, 1'b1, 1'b1, "R4");
    cyc(1'b0, 5'h00, 1'b1, 1'b0, "R9");

    // R7/R6: three retests then a match.
    do_reset();
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 12; k++) cyc(1'($urandom), 5'($urandom), 1'b0, 1'b0, "R4");
      cyc(1'b0, 5'h00, 1'b1, (p == 3), "R7");
    end
    cyc(1'b0, 5'h00, 1'b1, 1'b0, "R9");

    // R8: four failing compares, then a matching one is ignored.
    do_reset();
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 6; k++) cyc(1'b1, 5'($urandom), 1'b0, 1'b0, "R4");
      cyc(1'b1, 5'($urandom), 1'b1, 1'b0, "R8");
    end
    cyc(1'b1, 5'h1F, 1'b1, 1'b1, "R9");

    // R5: symbol in the end_of_test cycle is included.
    do_reset();
    cyc(1'b1, 5'h13, 1'b0, 1'b0, "R5");
    cyc(1'b1, 5'h07, 1'b1, 1'b1, "R5");

    // Random sessions.
    for (int s = 0; s < 40; s++) begin
      do_reset();
      for (int k = 0; k < 120; k++) begin
        logic e;
        e = ($urandom_range(0, 9) == 0);
        cyc(1'($urandom), 5'($urandom), e, ($urandom_range(0, 3) == 0), "R4");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule